// File: doc/BRIEF.md
# JTAG Test Access Port Controller

This block is the serial test controller of a chip: a sixteen-state machine driven by TMS on the rising edge of TCK, a three-bit instruction register with separate shift and hold stages, an instruction decoder, a 32-bit identification register and a one-bit bypass register. A board tester moves the state machine with TMS, shifts instructions and data through TDI, and reads results on TDO. TRST clears the controller asynchronously. The clear is released in step with TCK.

The decoded instruction drives select lines and a force-high-impedance line for the pad ring. When a boundary-scan instruction is active, three strobes tell an external boundary-scan chain when to capture, shift and update. The serial output of that chain comes back on a dedicated input and is routed to TDO. The hold stage loads the identification instruction on reset. After that it changes only on the falling edge of TCK, either in Update-IR or while the controller sits in Test-Logic-Reset.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: While trst_n is low, and after its release, the active instruction is IDCODE (opcode 001), tdo_oe is 0 and force_hiz is 0.
- R2: Capture-IR loads the pattern 001 into the instruction shift stage. Shifting out lsb first therefore gives 1, then 0, then 0 on TDO.
- R3: The instruction shift stage takes TDI at its msb and moves toward its lsb on rising TCK. The select outputs keep their value until the falling TCK edge in Update-IR.
- R4: The opcode map is 000 EXTEST (sel_extest), 100 SAMPLE/PRELOAD (sel_sample), 001 IDCODE (sel_idcode) and 101 HIGHZ (sel_bypass and force_hiz both 1). Every other opcode gives sel_bypass=1 and force_hiz=0.
- R5: With IDCODE active, Capture-DR loads the 32-bit ID_VALUE, whose lsb is 1. The value then shifts out lsb first.
- R6: With the bypass register selected, Capture-DR loads 0. The first bit read is therefore 0, and each later bit equals the TDI bit shifted in one clock earlier.
- R7: Five rising TCK edges with TMS high reach Test-Logic-Reset from any state. The falling edge after the fifth loads IDCODE, and after four edges the old instruction is still active.
- R8: tdo_oe is 1 only in the half cycle after a falling TCK edge that found the controller in Shift-IR or Shift-DR. TDO changes only on the falling edge of TCK.
- R9: Passing through the Exit1, Pause and Exit2 states and then back to Shift keeps the partly shifted IR or DR contents intact, and tdo_oe is 0 while paused.
- R10: With EXTEST or SAMPLE/PRELOAD active, TDO carries bsr_so during Shift-DR. bsr_capture, bsr_shift and bsr_update are high in Capture-DR, Shift-DR and Update-DR respectively.
- R11: Pulling trst_n low clears the active instruction to IDCODE and tdo_oe to 0 at once, without a TCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| bsr_so | input | 1 | Serial output of the external boundary-scan chain |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| tdo_oe | output | 1 | Output enable for TDO |
| sel_extest | output | 1 | EXTEST active |
| sel_sample | output | 1 | SAMPLE/PRELOAD active |
| sel_idcode | output | 1 | IDCODE active |
| sel_bypass | output | 1 | Bypass register is the data path |
| force_hiz | output | 1 | Force all outputs to high impedance |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |

## Verification
The bench keeps the three-bit opcode map and the two-stage reset synchronizer at their defaults. It overrides ID_VALUE with 32'hC0DE1235, so the full 32-bit shift-out is compared against a value that differs from the default. The unused opcodes 010 and 111 are exercised, and a scan is split across Pause-DR. Together these reach every one of the sixteen states. They also cover the TMS-only reset from Shift-DR, counted edge by edge, and an asynchronous reset taken in the middle of a shift.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  typedef enum logic [3:0] {
    ST_TLR,
    ST_RTI,
    ST_SEL_DR,
    ST_CAP_DR,
    ST_SHF_DR,
    ST_EX1_DR,
    ST_PAU_DR,
    ST_EX2_DR,
    ST_UPD_DR,
    ST_SEL_IR,
    ST_CAP_IR,
    ST_SHF_IR,
    ST_EX1_IR,
    ST_PAU_IR,
    ST_EX2_IR,
    ST_UPD_IR
  } tap_state_e;

  typedef struct packed {
    logic extest;
    logic sample;
    logic idcode;
    logic bypass;
    logic hiz;
  } instr_sel_t;

endpackage

// File: rtl/jtag_tap_rst_sync.sv
module jtag_tap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic tck,
  input  logic trst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_q;
  tap_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_TLR;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
  import jtag_tap_pkg::*;
#(
  parameter int              IR_W    = 3,
  parameter logic [IR_W-1:0] DEF_OP  = 3'b001,
  parameter logic [IR_W-1:0] CAP_PAT = 3'b001
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_sr,
  output logic [IR_W-1:0] ir_op
);

  logic [IR_W-1:0] sr_q, sr_d;
  logic            sr_en;
  logic [IR_W-1:0] op_q, op_d;
  logic            op_en;

  // shift stage: rising edge, msb nearest TDI
  always_comb begin
    sr_en = 1'b0;
    sr_d  = sr_q;
    if (state == ST_CAP_IR) begin
      sr_en = 1'b1;
      sr_d  = CAP_PAT;
    end else if (state == ST_SHF_IR) begin
      sr_en = 1'b1;
      sr_d  = {tdi, sr_q[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= DEF_OP;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  // hold stage: falling edge
  always_comb begin
    op_en = 1'b0;
    op_d  = op_q;
    if (state == ST_TLR) begin
      op_en = 1'b1;
      op_d  = DEF_OP;
    end else if (state == ST_UPD_IR) begin
      op_en = 1'b1;
      op_d  = sr_q;
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= DEF_OP;
    end else if (op_en) begin
      op_q <= op_d;
    end
  end

  assign ir_sr = sr_q;
  assign ir_op = op_q;

endmodule

// File: rtl/jtag_tap_decode.sv
module jtag_tap_decode
  import jtag_tap_pkg::*;
#(
  parameter int              IR_W      = 3,
  parameter logic [IR_W-1:0] OP_EXTEST = 3'b000,
  parameter logic [IR_W-1:0] OP_IDCODE = 3'b001,
  parameter logic [IR_W-1:0] OP_SAMPLE = 3'b100,
  parameter logic [IR_W-1:0] OP_HIGHZ  = 3'b101
) (
  input  logic [IR_W-1:0] ir_op,
  output instr_sel_t      sel
);

  always_comb begin
    sel.extest = (ir_op == OP_EXTEST);
    sel.sample = (ir_op == OP_SAMPLE);
    sel.idcode = (ir_op == OP_IDCODE);
    sel.hiz    = (ir_op == OP_HIGHZ);
    sel.bypass = !(sel.extest || sel.sample || sel.idcode);
  end

endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4A3C_90B7
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  input  logic            use_id,
  input  logic            use_byp,
  output logic [ID_W-1:0] id_sr,
  output logic            byp_q
);

  logic [ID_W-1:0] id_q, id_d;
  logic            id_en;
  logic            byp_d, byp_en;

  always_comb begin
    id_en = 1'b0;
    id_d  = id_q;
    if (use_id && state == ST_CAP_DR) begin
      id_en = 1'b1;
      id_d  = ID_VALUE;
    end else if (use_id && state == ST_SHF_DR) begin
      id_en = 1'b1;
      id_d  = {tdi, id_q[ID_W-1:1]};
    end
  end

  always_comb begin
    byp_en = 1'b0;
    byp_d  = byp_q;
    if (use_byp && state == ST_CAP_DR) begin
      byp_en = 1'b1;
      byp_d  = 1'b0;
    end else if (use_byp && state == ST_SHF_DR) begin
      byp_en = 1'b1;
      byp_d  = tdi;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= ID_VALUE;
    end else if (id_en) begin
      id_q <= id_d;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
    end else if (byp_en) begin
      byp_q <= byp_d;
    end
  end

  assign id_sr = id_q;

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter int              IR_W        = 3,
  parameter logic [IR_W-1:0] OP_EXTEST   = 3'b000,
  parameter logic [IR_W-1:0] OP_IDCODE   = 3'b001,
  parameter logic [IR_W-1:0] OP_SAMPLE   = 3'b100,
  parameter logic [IR_W-1:0] OP_HIGHZ    = 3'b101,
  parameter int              ID_W        = 32,
  parameter logic [ID_W-1:0] ID_VALUE    = 32'h4A3C_90B7,
  parameter int              SYNC_STAGES = 2
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_so,
  output logic tdo,
  output logic tdo_oe,
  output logic sel_extest,
  output logic sel_sample,
  output logic sel_idcode,
  output logic sel_bypass,
  output logic force_hiz,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update
);

  localparam logic [IR_W-1:0] CAP_PAT = OP_IDCODE;

  logic            rst_n;
  tap_state_e      state;
  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_op;
  instr_sel_t      sel;
  logic [ID_W-1:0] id_sr;
  logic            byp_q;
  logic            bsr_sel;
  logic            shifting;
  logic            tdo_d, tdo_q, oe_q;

  jtag_tap_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .tck    (tck),
    .trst_n (trst_n),
    .rst_n  (rst_n)
  );

  jtag_tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  jtag_tap_ir #(.IR_W(IR_W), .DEF_OP(OP_IDCODE), .CAP_PAT(CAP_PAT)) u_ir (
    .tck   (tck),
    .rst_n (rst_n),
    .tdi   (tdi),
    .state (state),
    .ir_sr (ir_sr),
    .ir_op (ir_op)
  );

  jtag_tap_decode #(
    .IR_W(IR_W), .OP_EXTEST(OP_EXTEST), .OP_IDCODE(OP_IDCODE),
    .OP_SAMPLE(OP_SAMPLE), .OP_HIGHZ(OP_HIGHZ)
  ) u_dec (
    .ir_op (ir_op),
    .sel   (sel)
  );

  jtag_tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck     (tck),
    .rst_n   (rst_n),
    .tdi     (tdi),
    .state   (state),
    .use_id  (sel.idcode),
    .use_byp (sel.bypass),
    .id_sr   (id_sr),
    .byp_q   (byp_q)
  );

  assign bsr_sel  = sel.extest || sel.sample;
  assign shifting = (state == ST_SHF_IR) || (state == ST_SHF_DR);

  always_comb begin
    tdo_d = tdo_q;
    if (state == ST_SHF_IR) begin
      tdo_d = ir_sr[0];
    end else if (state == ST_SHF_DR) begin
      if (sel.idcode)      tdo_d = id_sr[0];
      else if (sel.bypass) tdo_d = byp_q;
      else                 tdo_d = bsr_so;
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= shifting;
      if (shifting) begin
        tdo_q <= tdo_d;
      end
    end
  end

  assign tdo         = tdo_q;
  assign tdo_oe      = oe_q;
  assign sel_extest  = sel.extest;
  assign sel_sample  = sel.sample;
  assign sel_idcode  = sel.idcode;
  assign sel_bypass  = sel.bypass;
  assign force_hiz   = sel.hiz;
  assign bsr_capture = bsr_sel && (state == ST_CAP_DR);
  assign bsr_shift   = bsr_sel && (state == ST_SHF_DR);
  assign bsr_update  = bsr_sel && (state == ST_UPD_DR);

endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
  import jtag_tap_pkg::*;
#(
  parameter int              IR_W     = 3,
  parameter logic [IR_W-1:0] DEF_OP   = 3'b001,
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4A3C_90B7
) (
  input logic            tck,
  input logic            rst_n,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_sr,
  input logic [IR_W-1:0] ir_op,
  input logic [ID_W-1:0] id_sr,
  input logic            byp_q,
  input logic            tdo_oe,
  input logic            sel_idcode,
  input logic            sel_bypass,
  input logic            force_hiz
);

  // R2: capture pattern lands in the shift stage
  a_r2_capture_pattern: assert property (@(posedge tck) disable iff (!rst_n)
    state == ST_CAP_IR |=> ir_sr == DEF_OP);

  // R3: hold stage changes only across Update-IR or Test-Logic-Reset
  a_r3_hold_stable: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_UPD_IR && state != ST_TLR) |-> $stable(ir_op));

  // R4: HIGHZ routes through bypass
  a_r4_hiz_bypass: assert property (@(posedge tck) disable iff (!rst_n)
    force_hiz |-> sel_bypass);

  // R5: identification value captured
  a_r5_id_capture: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR && sel_idcode) |=> id_sr == ID_VALUE);

  // R6: bypass captures zero
  a_r6_byp_capture: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR && sel_bypass) |=> !byp_q);

  // R7: Test-Logic-Reset holds the default instruction
  a_r7_tlr_default: assert property (@(posedge tck) disable iff (!rst_n)
    state == ST_TLR |-> sel_idcode);

  // R8: output enable only in shift states
  a_r8_oe_shift_only: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe == (state == ST_SHF_IR || state == ST_SHF_DR));

endmodule

bind jtag_tap_ctrl jtag_tap_chk #(
  .IR_W(IR_W), .DEF_OP(OP_IDCODE), .ID_W(ID_W), .ID_VALUE(ID_VALUE)
) u_chk (
  .tck        (tck),
  .rst_n      (rst_n),
  .state      (state),
  .ir_sr      (ir_sr),
  .ir_op      (ir_op),
  .id_sr      (id_sr),
  .byp_q      (byp_q),
  .tdo_oe     (tdo_oe),
  .sel_idcode (sel_idcode),
  .sel_bypass (sel_bypass),
  .force_hiz  (force_hiz)
);

// File: tb/test_jtag_tap_ctrl.sv
`timescale 1ns/1ps
module test_jtag_tap_ctrl;

  localparam logic [31:0] EXP_ID = 32'hC0DE_1235;

  logic tck = 1'b0;
  logic trst_n, tms, tdi, bsr_so;
  logic tdo, tdo_oe, sel_extest, sel_sample, sel_idcode, sel_bypass, force_hiz;
  logic bsr_capture, bsr_shift, bsr_update;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic s_tdo, s_oe;

  always #2.5 tck = ~tck;

  jtag_tap_ctrl #(.ID_VALUE(EXP_ID)) i_jtag_tap_ctrl (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_so(bsr_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .sel_extest(sel_extest), .sel_sample(sel_sample),
    .sel_idcode(sel_idcode), .sel_bypass(sel_bypass), .force_hiz(force_hiz),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // samples outputs (stable since last falling edge), then runs one TCK period
  task automatic step(input logic t, input logic d);
    s_tdo = tdo;
    s_oe  = tdo_oe;
    tms = t;
    tdi = d;
    @(negedge tck);
    #1;
  endtask

  task automatic hard_reset();
    trst_n = 1'b0;
    tms = 1'b1;
    repeat (3) step(1'b1, 1'b0);
    trst_n = 1'b1;
    repeat (3) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  // from Run-Test/Idle; returns captured bits and selects before update
  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap,
                         output logic [3:0] pre_sel);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, op[i]);
      cap[i] = s_tdo;
      chk(s_oe === 1'b1, "R8 oe in Shift-IR", {31'd0, s_oe}, 32'd1);
    end
    pre_sel = {sel_extest, sel_sample, sel_idcode, sel_bypass};
    step(1, 0);
    step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      dout[i] = s_tdo;
    end
    step(1, 0);
    step(0, 0);
  endtask

  task automatic t_reset();
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; bsr_so = 1'b0;
    @(negedge tck); #1;
    chk(sel_idcode === 1'b1, "R1 idcode in reset", {31'd0, sel_idcode}, 32'd1);
    chk(tdo_oe === 1'b0, "R1 oe in reset", {31'd0, tdo_oe}, 32'd0);
    chk(force_hiz === 1'b0, "R1 hiz in reset", {31'd0, force_hiz}, 32'd0);
    hard_reset();
    chk(sel_idcode === 1'b1, "R1 idcode after release", {31'd0, sel_idcode}, 32'd1);
  endtask

  task automatic t_ir_capture();
    logic [2:0] cap; logic [3:0] pre;
    load_ir(3'b000, cap, pre);
    chk(cap === 3'b001, "R2 capture-IR pattern", {29'd0, cap}, 32'd1);
    chk(pre === 4'b0010, "R3 select held until Update-IR", {28'd0, pre}, 32'b0010);
    chk(sel_extest === 1'b1, "R3 EXTEST active after update", {31'd0, sel_extest}, 32'd1);
    chk(sel_bypass === 1'b0 && force_hiz === 1'b0, "R4 EXTEST not bypass",
        {30'd0, sel_bypass, force_hiz}, 32'd0);
  endtask

  task automatic t_idcode();
    logic [2:0] cap; logic [3:0] pre; logic [31:0] d;
    load_ir(3'b001, cap, pre);
    chk(sel_idcode === 1'b1, "R4 IDCODE decode", {31'd0, sel_idcode}, 32'd1);
    scan_dr(32, 32'h0, d);
    chk(d[0] === 1'b1, "R5 first ID bit", {31'd0, d[0]}, 32'd1);
    chk(d === EXP_ID, "R5 ID shift-out", d, EXP_ID);
  endtask

  task automatic t_bypass();
    logic [2:0] cap; logic [3:0] pre; logic [31:0] d;
    logic [7:0] pat = 8'b1011_0011;
    load_ir(3'b010, cap, pre);
    chk(sel_bypass === 1'b1 && force_hiz === 1'b0, "R4 unassigned 010 bypass",
        {30'd0, sel_bypass, force_hiz}, 32'b10);
    scan_dr(8, {24'd0, pat}, d);
    chk(d[7:0] === {pat[6:0], 1'b0}, "R6 bypass delay", {24'd0, d[7:0]},
        {24'd0, pat[6:0], 1'b0});
    load_ir(3'b111, cap, pre);
    chk(sel_bypass === 1'b1 && sel_idcode === 1'b0, "R4 unassigned 111 bypass",
        {30'd0, sel_bypass, sel_idcode}, 32'b10);
  endtask

  task automatic t_highz_pause_ir();
    // shift 101 with a pause after the first bit
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    step(1, 1'b1);
    chk(s_tdo === 1'b1, "R2 first IR bit", {31'd0, s_tdo}, 32'd1);
    step(0, 0); step(0, 0);
    chk(s_oe === 1'b0, "R9 oe low in Pause-IR", {31'd0, s_oe}, 32'd0);
    step(1, 0); step(0, 0);
    step(0, 1'b0);
    chk(s_tdo === 1'b0, "R9 IR resume bit", {31'd0, s_tdo}, 32'd0);
    step(1, 1'b1);
    step(1, 0); step(0, 0);
    chk(force_hiz === 1'b1 && sel_bypass === 1'b1, "R4 HIGHZ decode",
        {30'd0, force_hiz, sel_bypass}, 32'b11);
  endtask

  task automatic t_pause_dr();
    logic [2:0] cap; logic [3:0] pre; logic [31:0] d = '0;
    load_ir(3'b001, cap, pre);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 8; i++) begin
      step(i == 7, 0);
      d[i] = s_tdo;
    end
    step(0, 0); step(0, 0);
    chk(s_oe === 1'b0, "R9 oe low in Pause-DR", {31'd0, s_oe}, 32'd0);
    step(1, 0); step(0, 0);
    for (int i = 8; i < 32; i++) begin
      step(i == 31, 0);
      d[i] = s_tdo;
    end
    step(1, 0); step(0, 0);
    chk(d === EXP_ID, "R9 ID across Pause-DR", d, EXP_ID);
  endtask

  task automatic t_bsr();
    logic [2:0] cap; logic [3:0] pre; logic [31:0] d;
    load_ir(3'b000, cap, pre);
    bsr_so = 1'b1;
    step(1, 0); step(0, 0);
    chk(bsr_capture === 1'b1, "R10 capture strobe", {31'd0, bsr_capture}, 32'd1);
    step(0, 0);
    chk(bsr_shift === 1'b1, "R10 shift strobe", {31'd0, bsr_shift}, 32'd1);
    d = '0;
    for (int i = 0; i < 4; i++) begin
      step(i == 3, 0);
      d[i] = s_tdo;
    end
    chk(d[3:0] === 4'hF, "R10 TDO follows chain", {28'd0, d[3:0]}, 32'hF);
    step(1, 0);
    chk(bsr_update === 1'b1, "R10 update strobe", {31'd0, bsr_update}, 32'd1);
    step(0, 0);
    chk(bsr_update === 1'b0, "R10 update ends", {31'd0, bsr_update}, 32'd0);
    load_ir(3'b100, cap, pre);
    chk(sel_sample === 1'b1, "R4 SAMPLE decode", {31'd0, sel_sample}, 32'd1);
    bsr_so = 1'b0;
    scan_dr(4, 32'hF, d);
    chk(d[3:0] === 4'h0, "R10 SAMPLE path", {28'd0, d[3:0]}, 32'h0);
  endtask

  task automatic t_tms_reset();
    logic [2:0] cap; logic [3:0] pre;
    load_ir(3'b000, cap, pre);
    step(1, 0); step(0, 0); step(0, 0);
    repeat (4) step(1, 0);
    chk(sel_extest === 1'b1, "R7 four TMS-high edges keep instr",
        {31'd0, sel_extest}, 32'd1);
    step(1, 0);
    chk(sel_idcode === 1'b1, "R7 fifth edge loads IDCODE", {31'd0, sel_idcode}, 32'd1);
    step(0, 0);
  endtask

  task automatic t_async();
    logic [2:0] cap; logic [3:0] pre;
    load_ir(3'b000, cap, pre);
    step(1, 0); step(0, 0); step(0, 0);
    chk(tdo_oe === 1'b1, "R8 oe in Shift-DR", {31'd0, tdo_oe}, 32'd1);
    #0.5 trst_n = 1'b0;
    #0.3;
    chk(sel_idcode === 1'b1, "R11 async idcode", {31'd0, sel_idcode}, 32'd1);
    chk(tdo_oe === 1'b0, "R11 async oe clear", {31'd0, tdo_oe}, 32'd0);
    @(negedge tck); #1;
    hard_reset();
  endtask

  initial begin
    t_reset();
    t_ir_capture();
    t_idcode();
    t_bypass();
    t_highz_pause_ir();
    t_pause_dr();
    t_bsr();
    t_tms_reset();
    t_async();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule